// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits between a bus-cycle sequencer and the external bus. It enforces a programmable number of dead clocks between one external access and the next. This gives a slow device's output buffer time to release the data lines before the next access drives them. The block remembers three things about the last access it let through: whether it was a read or a write, which chip-select space it targeted, and whether it was a DMA single-address transfer. When the next request is offered, the block classifies the transition and fetches a 3-bit gap code from the configuration of the space the new access targets. It turns the code into a clock count and holds the request back until that many idle clocks have passed since the previous access ended.

Requests use a valid/ready handshake. The sequencer raises `req_valid` with the attributes `req_write`, `req_space` and `req_dma`. It must keep all of them steady until a cycle in which `req_ready` is also high; that cycle is the first cycle of the new access. `req_ready` is a function of the offered attributes, so it may be high while `req_valid` is low, which shows that an access with those attributes could start now. After an access is accepted, the block refuses new requests until the sequencer pulses `acc_done` in the access's last cycle. Idle clocks are counted from the cycle after that pulse. Clocks that pass before a request is offered count toward the gap.

Top module: `idle_gap_inserter`

## Requirements
- R1: After reset, and until the first access has been accepted, `req_ready` is high for any attributes: no previous access means zero idle clocks.
- R2: After a write, the gap for the next access of either direction comes from field bits [14:12] of the new space's configuration slice.
- R3: A read followed by a write to a different space uses field bits [11:9].
- R4: A read followed by a write to the same space uses field bits [8:6].
- R5: A read followed by a read of a different space uses field bits [5:3].
- R6: A read followed by a read of the same space uses field bits [2:0].
- R7: The configuration slice for space s is `cfg_gap[s*15 +: 15]`, and the slice of the new access's space is the one consulted.
- R8: Gap codes 0 to 7 stand for 0, 1, 2, 4, 6, 8, 10 and 12 idle clocks.
- R9: With `dma_gap_any` low, the DMA code `dma_gap_code` applies only when both the previous and the new access are DMA transfers. When it applies, the gap is the larger of the DMA gap and the class gap; otherwise the class gap alone is used.
- R10: With `dma_gap_any` high, the DMA code applies when either access is a DMA transfer, with the same larger-of rule.
- R11: `req_ready` is low from the cycle after an accept through the cycle in which `acc_done` is high.
- R12: If the end pulse of the previous access is in cycle t and the gap is G clocks, `req_ready` first goes high in cycle t+1+G. It then stays high while the offered attributes are held and nothing is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Next access is offered |
| req_ready | output | 1 | Access with the offered attributes may start this cycle |
| req_write | input | 1 | Offered access is a write (1) or read (0) |
| req_space | input | SPACE_W | Chip-select space of the offered access |
| req_dma | input | 1 | Offered access is a DMA single-address transfer |
| acc_done | input | 1 | Last cycle of the access in progress |
| cfg_gap | input | NSPACE*15 | Per-space gap codes, five 3-bit fields per space |
| dma_gap_code | input | 3 | Gap code for DMA transfers |
| dma_gap_any | input | 1 | DMA code applies when either access (1) or both accesses (0) are DMA |

## Verification
`req_ready` responds combinationally to the offered attributes. Its timing is anchored to the `acc_done` pulse: G idle clocks later it rises, in cycle t+1+G, and it falls one cycle after an accept. The bench drives inputs one time unit after a rising edge and samples at the falling edge. It counts low-ready falling edges starting with the first cycle after the end pulse, so the count must equal G exactly. It also samples one cycle past the rise to confirm that ready holds, and one cycle past each accept to confirm that ready drops.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

  localparam int CFG_W   = 15;
  localparam int GAP_MAX = 12;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  // Per-space gap fields, most significant first
  typedef struct packed {
    logic [2:0] after_wr;   // [14:12]
    logic [2:0] rw_diff;    // [11:9]
    logic [2:0] rw_same;    // [8:6]
    logic [2:0] rr_diff;    // [5:3]
    logic [2:0] rr_same;    // [2:0]
  } gap_cfg_t;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_AFTER_WR,
    CLS_RW_DIFF,
    CLS_RW_SAME,
    CLS_RR_DIFF,
    CLS_RR_SAME
  } gap_class_e;

  // code 0..2 -> itself, 3..7 -> 2*(code-1)
  function automatic logic [GAP_W-1:0] gap_cycles(input logic [2:0] code);
    logic [GAP_W-1:0] c;
    c = GAP_W'(code);
    if (code < 3'd3) return c;
    return (c << 1) - GAP_W'(2);
  endfunction

endpackage

// File: rtl/idle_gap_select.sv
module idle_gap_select
  import idle_gap_pkg::*;
#(
  parameter int NSPACE  = 8,
  parameter int SPACE_W = $clog2(NSPACE)
) (
  input  logic [NSPACE*CFG_W-1:0] cfg_flat,
  input  logic [SPACE_W-1:0]      space,
  output gap_cfg_t                sel
);

  gap_cfg_t tbl [NSPACE];

  for (genvar g = 0; g < NSPACE; g++) begin : g_unpack
    assign tbl[g] = cfg_flat[g*CFG_W +: CFG_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NSPACE; i++) begin
      if (space == SPACE_W'(i)) sel = tbl[i];
    end
  end

endmodule

// File: rtl/idle_gap_classify.sv
module idle_gap_classify
  import idle_gap_pkg::*;
#(
  parameter int SPACE_W = 3
) (
  input  logic               has_prev,
  input  logic               prev_write,
  input  logic [SPACE_W-1:0] prev_space,
  input  logic               prev_dma,
  input  logic               new_write,
  input  logic [SPACE_W-1:0] new_space,
  input  logic               new_dma,
  input  gap_cfg_t           cfg,
  input  logic [2:0]         dma_code,
  input  logic               dma_any,
  output logic [GAP_W-1:0]   need
);

  gap_class_e       cls;
  logic [2:0]       cls_code;
  logic [GAP_W-1:0] cls_cyc;
  logic [GAP_W-1:0] dma_cyc;
  logic             same;
  logic             dma_on;

  assign same = (prev_space == new_space);

  always_comb begin
    if (!has_prev)       cls = CLS_NONE;
    else if (prev_write) cls = CLS_AFTER_WR;
    else if (new_write)  cls = same ? CLS_RW_SAME : CLS_RW_DIFF;
    else                 cls = same ? CLS_RR_SAME : CLS_RR_DIFF;
  end

  always_comb begin
    unique case (cls)
      CLS_AFTER_WR: cls_code = cfg.after_wr;
      CLS_RW_DIFF:  cls_code = cfg.rw_diff;
      CLS_RW_SAME:  cls_code = cfg.rw_same;
      CLS_RR_DIFF:  cls_code = cfg.rr_diff;
      CLS_RR_SAME:  cls_code = cfg.rr_same;
      default:      cls_code = 3'd0;
    endcase
  end

  assign cls_cyc = gap_cycles(cls_code);
  assign dma_cyc = gap_cycles(dma_code);
  assign dma_on  = has_prev && (dma_any ? (prev_dma | new_dma) : (prev_dma & new_dma));

  always_comb begin
    need = cls_cyc;
    if (dma_on && dma_cyc > cls_cyc) need = dma_cyc;
  end

endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
  import idle_gap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             acc_done,
  output logic             active,
  output logic [GAP_W-1:0] elapsed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      elapsed <= '0;
    end else if (accept) begin
      active  <= 1'b1;
    end else if (active) begin
      if (acc_done) begin
        active  <= 1'b0;
        elapsed <= '0;
      end
    end else if (elapsed != GAP_W'(GAP_MAX)) begin
      elapsed <= elapsed + GAP_W'(1);
    end
  end

endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
  import idle_gap_pkg::*;
#(
  parameter int NSPACE  = 8,
  parameter int SPACE_W = $clog2(NSPACE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [SPACE_W-1:0]      req_space,
  input  logic                    req_dma,
  input  logic                    acc_done,
  input  logic [NSPACE*CFG_W-1:0] cfg_gap,
  input  logic [2:0]              dma_gap_code,
  input  logic                    dma_gap_any
);

  logic               has_prev;
  logic               prev_write;
  logic [SPACE_W-1:0] prev_space;
  logic               prev_dma;
  logic               active;
  logic [GAP_W-1:0]   elapsed;
  logic [GAP_W-1:0]   need;
  logic               accept;
  gap_cfg_t           space_cfg;

  assign accept    = req_valid && req_ready;
  assign req_ready = !active && (elapsed >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_prev   <= 1'b0;
      prev_write <= 1'b0;
      prev_space <= '0;
      prev_dma   <= 1'b0;
    end else if (accept) begin
      has_prev   <= 1'b1;
      prev_write <= req_write;
      prev_space <= req_space;
      prev_dma   <= req_dma;
    end
  end

  idle_gap_select #(.NSPACE(NSPACE), .SPACE_W(SPACE_W)) u_sel (
    .cfg_flat (cfg_gap),
    .space    (req_space),
    .sel      (space_cfg)
  );

  idle_gap_classify #(.SPACE_W(SPACE_W)) u_cls (
    .has_prev   (has_prev),
    .prev_write (prev_write),
    .prev_space (prev_space),
    .prev_dma   (prev_dma),
    .new_write  (req_write),
    .new_space  (req_space),
    .new_dma    (req_dma),
    .cfg        (space_cfg),
    .dma_code   (dma_gap_code),
    .dma_any    (dma_gap_any),
    .need       (need)
  );

  idle_gap_timer u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .acc_done (acc_done),
    .active   (active),
    .elapsed  (elapsed)
  );

endmodule

// File: rtl/idle_gap_checker.sv
module idle_gap_checker
  import idle_gap_pkg::*;
#(
  parameter int SPACE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [SPACE_W-1:0] req_space,
  input logic               req_dma,
  input logic               acc_done,
  input logic               active,
  input logic               has_prev,
  input logic [GAP_W-1:0]   need
);

  logic [GAP_W-1:0] own_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  own_idle <= '0;
    else if (active && acc_done) own_idle <= '0;
    else if (!active && own_idle != GAP_W'(GAP_MAX)) own_idle <= own_idle + GAP_W'(1);
  end

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !req_ready);                                               // R11
  AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);                             // R11
  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_prev && !active) |-> req_ready);                                // R1
  AST_GAP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && has_prev) |-> (own_idle >= need));         // R12
  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_ready && !req_valid) && !active && $stable(req_write) &&
     $stable(req_space) && $stable(req_dma)) |-> req_ready);              // R12
  AST_NEED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    need <= GAP_W'(GAP_MAX));                                             // R8

endmodule

bind idle_gap_inserter idle_gap_checker #(.SPACE_W(SPACE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_space (req_space),
  .req_dma   (req_dma),
  .acc_done  (acc_done),
  .active    (active),
  .has_prev  (has_prev),
  .need      (need)
);

// File: tb/tb_idle_gap_inserter.sv
module tb_idle_gap_inserter;
  localparam int CLK_PERIOD = 10;
  localparam int NSP = 4;
  localparam int SPW = 2;
  localparam int FW  = 15;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           rst_n, req_valid, req_ready, req_write, req_dma, acc_done, dma_gap_any;
  logic [SPW-1:0] req_space;
  logic [NSP*FW-1:0] cfg_gap;
  logic [2:0]     dma_gap_code;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  idle_gap_inserter #(.NSPACE(NSP), .SPACE_W(SPW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_space(req_space), .req_dma(req_dma),
    .acc_done(acc_done), .cfg_gap(cfg_gap), .dma_gap_code(dma_gap_code),
    .dma_gap_any(dma_gap_any)
  );

  function automatic int dec(int c);
    return (c < 3) ? c : 2 * (c - 1);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic issue(input bit w, input int s, input bit d);
    req_write = w; req_space = SPW'(s); req_dma = d; req_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req_ready) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_access;
    step;
    acc_done = 1'b1;
    step;
    acc_done = 1'b0;
  endtask

  task automatic measure(input bit w, input int s, input bit d, input int exp, input string tag);
    int k;
    k = 0;
    req_write = w; req_space = SPW'(s); req_dma = d; req_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (req_ready) break;
      k++;
      @(posedge clk); #1;
    end
    check(tag, k, exp);
    step;
    @(negedge clk);
    check("R12 ready held", int'(req_ready), 1);
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check("R11 busy after accept", int'(req_ready), 0);
    finish_access;
  endtask

  task automatic run_pair(input bit pw, input int ps, input bit pd,
                          input bit nw, input int ns, input bit nd,
                          input int exp, input string tag);
    issue(pw, ps, pd);
    finish_access;
    measure(nw, ns, nd, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R12 actual=hang expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_dma = 1'b0; req_space = '0;
    acc_done = 1'b0; cfg_gap = '1; dma_gap_code = 3'd7; dma_gap_any = 1'b1;
    repeat (3) step;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    step;
    req_write = 1'b1; req_space = 2'd2; req_dma = 1'b1;
    @(negedge clk);
    check("R1 no previous access", int'(req_ready), 1);
    step;

    // class sweep: every transition class, every code, same and different space
    for (int pw = 0; pw < 2; pw++)
      for (int nw = 0; nw < 2; nw++)
        for (int sm = 0; sm < 2; sm++)
          for (int c = 0; c < 8; c++) begin
            int fld, ns;
            string tag;
            ns = sm ? 1 : 2;
            fld = pw ? 4 : (nw ? (sm ? 2 : 3) : (sm ? 0 : 1));
            tag = pw ? "R2" : (nw ? (sm ? "R4" : "R3") : (sm ? "R6" : "R5"));
            for (int s = 0; s < NSP; s++)
              for (int f = 0; f < 5; f++)
                cfg_gap[s*FW + f*3 +: 3] = 3'((c + 3) % 8);
            cfg_gap[ns*FW + fld*3 +: 3] = 3'(c);
            dma_gap_code = 3'd7; dma_gap_any = 1'b0;
            run_pair(pw[0], 1, 1'b0, nw[0], ns, 1'b0, dec(c), {tag, " R7 R8 gap"});
          end

    // DMA sweep: class gap fixed at 2 clocks, read-read same space
    cfg_gap = '0;
    for (int s = 0; s < NSP; s++) cfg_gap[s*FW +: 3] = 3'd2;
    for (int md = 0; md < 2; md++)
      for (int pd = 0; pd < 2; pd++)
        for (int nd = 0; nd < 2; nd++)
          for (int d = 0; d < 8; d++) begin
            bit ap;
            int ex;
            ap = md ? (pd != 0 || nd != 0) : (pd != 0 && nd != 0);
            ex = (ap && dec(d) > 2) ? dec(d) : 2;
            dma_gap_any = md[0]; dma_gap_code = 3'(d);
            run_pair(1'b0, 3, pd[0], 1'b0, 3, nd[0], ex, md ? "R10 dma gap" : "R9 dma gap");
          end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule